// File: doc/BRIEF.md
# Tamper Pin Filter and Compare Channel

This block is a single tamper pin channel. It brings an asynchronous pin level into the clock domain, removes short glitches with a tick-qualified debounce filter, and compares the settled level with an expected value. The expected value is one of four choices: a constant zero, either of two active-tamper pattern streams, or the XOR of the two streams. It can also be inverted. When the channel is set up to drive the pin, it outputs the inverse of the expected value and does no comparing. When the pin is an input and a difference starts, the channel raises a one-cycle pulse that sets the pin's tamper flag elsewhere.

The filter runs from one of two slow tick strobes, a low-rate one and a high-rate one, which a configuration bit selects. A 6-bit width field sets how many ticks a new level must hold. The filter is a three-state machine:

- FLT_BYPASS: the filter is disabled and follows the synchronized input.
- FLT_STABLE: the filter holds its settled level.
- FLT_QUAL: the filter is counting ticks for a candidate level.

The transitions are:

- enable (FLT_BYPASS to FLT_STABLE)
- disable (any state to FLT_BYPASS)
- change seen (FLT_STABLE to FLT_QUAL)
- abort, when the input returns to the settled level (FLT_QUAL to FLT_STABLE)
- accept, on the qualifying tick (FLT_QUAL to FLT_STABLE)

Top module: `tpin_chan`

## Requirements
- R1: While rst_n is low, raw_rd and mismatch are 0, and the filter is in FLT_BYPASS with a settled level of 0.
- R2: pin_raw passes through two flops. raw_rd shows the pin level sampled two rising edges earlier, before any filtering.
- R3: When cfg_filt_en is 0, the filtered level equals the synchronized level (raw_rd) in the same cycle.
- R4: When cfg_filt_en is 1, the settled level changes only after the synchronized level differs from it continuously for the cycle that enters FLT_QUAL and then for cfg_width+1 selected ticks. A return to the settled level before that aborts the change.
- R5: cfg_fast_sel = 0 makes the filter count tick_slow, and cfg_fast_sel = 1 makes it count tick_fast. The unselected tick has no effect.
- R6: cfg_exp_sel chooses the base expected value. 2'b00 gives 0, 2'b01 gives pat0, 2'b10 gives pat1, and 2'b11 gives pat0 XOR pat1.
- R7: cfg_invert = 1 inverts the base expected value.
- R8: pin_oe equals cfg_drive. While cfg_drive is 1, pin_out is the inverse of the expected value. While cfg_drive is 0, pin_out is 0.
- R9: While cfg_drive is 0, a cycle in which the filtered level first differs from the expected value gives a mismatch pulse of exactly one cycle on the following clock edge. Driving cycles never produce a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Asynchronous pin level |
| tick_slow | input | 1 | Low-rate filter tick strobe |
| tick_fast | input | 1 | High-rate filter tick strobe |
| pat0 | input | 1 | Active-tamper pattern stream 0 |
| pat1 | input | 1 | Active-tamper pattern stream 1 |
| cfg_width | input | 6 | Filter width in ticks, minus one |
| cfg_fast_sel | input | 1 | Tick select: 0 slow, 1 fast |
| cfg_filt_en | input | 1 | Filter enable |
| cfg_exp_sel | input | 2 | Expected-value source select |
| cfg_invert | input | 1 | Invert the expected value |
| cfg_drive | input | 1 | 1 makes the pin an output |
| mismatch | output | 1 | One-cycle tamper detection pulse |
| pin_out | output | 1 | Pin output data |
| pin_oe | output | 1 | Pin output enable |
| raw_rd | output | 1 | Synchronized unfiltered pin level |

## Verification
The hardest situation to reach from the ports is a qualification that stops on the last tick. For that, the input must stay at a new level for exactly cfg_width ticks and then fall back, which only happens with sparse ticks, a small width and rare pin toggles all at once. The stimulus therefore starts with directed runs: a fast tick on every cycle, glitches one cycle shorter than the window, then a hold past it. The random phase then keeps the width small and toggles the pin with low probability. A cycle-level reference model checks the pulses and data outputs on every cycle.

// File: rtl/tpin_pkg.sv
package tpin_pkg;
    typedef enum logic [1:0] {
        FLT_BYPASS = 2'd0,
        FLT_STABLE = 2'd1,
        FLT_QUAL   = 2'd2
    } flt_state_e;

    typedef enum logic [1:0] {
        EXP_ZERO = 2'b00,
        EXP_PAT0 = 2'b01,
        EXP_PAT1 = 2'b10,
        EXP_XOR  = 2'b11
    } exp_sel_e;
endpackage

// File: rtl/tpin_sync.sv
module tpin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tpin_filter.sv
module tpin_filter
    import tpin_pkg::*;
#(
    parameter int WIDTH_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               din,
    input  logic               tick,
    input  logic               en,
    input  logic [WIDTH_W-1:0] width,
    output logic               dout
);
    flt_state_e         state_q, state_d;
    logic               lvl_q;
    logic [WIDTH_W-1:0] cnt_q;
    logic               accept;

    // qualifying tick with the candidate still present
    assign accept = en && (din != lvl_q) && tick && (cnt_q >= width);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLT_BYPASS;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_BYPASS: if (en) state_d = FLT_STABLE;
            FLT_STABLE: begin
                if (!en)               state_d = FLT_BYPASS;
                else if (din != lvl_q) state_d = FLT_QUAL;
            end
            FLT_QUAL: begin
                if (!en)               state_d = FLT_BYPASS;
                else if (din == lvl_q) state_d = FLT_STABLE;
                else if (accept)       state_d = FLT_STABLE;
            end
            default:                   state_d = FLT_BYPASS;
        endcase
    end

    // outputs: settled level and tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                FLT_BYPASS: begin
                    lvl_q <= din;
                    cnt_q <= '0;
                end
                FLT_STABLE: cnt_q <= '0;
                FLT_QUAL: begin
                    if (accept) begin
                        lvl_q <= din;
                        cnt_q <= '0;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign dout = en ? lvl_q : din;
endmodule

// File: rtl/tpin_expect.sv
module tpin_expect
    import tpin_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       pat0,
    input  logic       pat1,
    input  logic       invert,
    output logic       exp_o
);
    logic base;

    always_comb begin
        unique case (exp_sel_e'(sel))
            EXP_ZERO: base = 1'b0;
            EXP_PAT0: base = pat0;
            EXP_PAT1: base = pat1;
            EXP_XOR:  base = pat0 ^ pat1;
            default:  base = 1'b0;
        endcase
    end

    assign exp_o = base ^ invert;
endmodule

// File: rtl/tpin_chan.sv
module tpin_chan
    import tpin_pkg::*;
#(
    parameter int WIDTH_W     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_raw,
    input  logic               tick_slow,
    input  logic               tick_fast,
    input  logic               pat0,
    input  logic               pat1,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic               cfg_fast_sel,
    input  logic               cfg_filt_en,
    input  logic [1:0]         cfg_exp_sel,
    input  logic               cfg_invert,
    input  logic               cfg_drive,
    output logic               mismatch,
    output logic               pin_out,
    output logic               pin_oe,
    output logic               raw_rd
);
    logic sync_lvl;
    logic filt_lvl;
    logic exp_lvl;
    logic tick_sel;
    logic diff_now;
    logic diff_q;
    logic pulse_q;

    tpin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (sync_lvl)
    );

    assign tick_sel = cfg_fast_sel ? tick_fast : tick_slow;

    tpin_filter #(.WIDTH_W(WIDTH_W)) filt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_lvl),
        .tick  (tick_sel),
        .en    (cfg_filt_en),
        .width (cfg_width),
        .dout  (filt_lvl)
    );

    tpin_expect exp_i (
        .sel    (cfg_exp_sel),
        .pat0   (pat0),
        .pat1   (pat1),
        .invert (cfg_invert),
        .exp_o  (exp_lvl)
    );

    assign diff_now = !cfg_drive && (filt_lvl != exp_lvl);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diff_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            diff_q  <= diff_now;
            pulse_q <= diff_now && !diff_q;
        end
    end

    assign mismatch = pulse_q;
    assign pin_oe   = cfg_drive;
    assign pin_out  = cfg_drive & ~exp_lvl;
    assign raw_rd   = sync_lvl;
endmodule

// File: rtl/tpin_chan_chk.sv
module tpin_chan_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pin_raw,
    input logic       cfg_drive,
    input logic [1:0] cfg_exp_sel,
    input logic       cfg_invert,
    input logic       mismatch,
    input logic       pin_out,
    input logic       pin_oe,
    input logic       raw_rd
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!mismatch && !raw_rd));

    assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (raw_rd == $past(pin_raw, 2)));

    assert_zero_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_drive && cfg_exp_sel == 2'b00 && !cfg_invert) |-> pin_out);

    assert_out_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_out);

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> !mismatch);

    assert_no_pulse_driving_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && $past(cfg_drive)) |-> !mismatch);
endmodule

bind tpin_chan tpin_chan_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_raw     (pin_raw),
    .cfg_drive   (cfg_drive),
    .cfg_exp_sel (cfg_exp_sel),
    .cfg_invert  (cfg_invert),
    .mismatch    (mismatch),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .raw_rd      (raw_rd)
);

// File: tb/tpin_chan_tb.sv
module tpin_chan_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_raw = 1'b0, tick_slow = 1'b0, tick_fast = 1'b0;
    logic       pat0 = 1'b0, pat1 = 1'b0;
    logic [5:0] cfg_width = '0;
    logic       cfg_fast_sel = 1'b0, cfg_filt_en = 1'b0;
    logic [1:0] cfg_exp_sel = 2'b00;
    logic       cfg_invert = 1'b0, cfg_drive = 1'b0;
    logic       mismatch, pin_out, pin_oe, raw_rd;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference model state
    logic       m_s1 = 0, m_s2 = 0, m_lvl = 0, m_diff = 0, m_mm = 0;
    int         m_st = 0;
    int         m_cnt = 0;

    always #4 clk = ~clk;

    tpin_chan dut_i (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .tick_slow(tick_slow),
        .tick_fast(tick_fast), .pat0(pat0), .pat1(pat1), .cfg_width(cfg_width),
        .cfg_fast_sel(cfg_fast_sel), .cfg_filt_en(cfg_filt_en),
        .cfg_exp_sel(cfg_exp_sel), .cfg_invert(cfg_invert), .cfg_drive(cfg_drive),
        .mismatch(mismatch), .pin_out(pin_out), .pin_oe(pin_oe), .raw_rd(raw_rd)
    );

    // R6 and R7: expected value from the encoding
    function automatic logic exp_of(logic [1:0] s, logic a, logic b, logic inv);
        logic base;
        case (s)
            2'b00:   base = 1'b0;
            2'b01:   base = a;
            2'b10:   base = b;
            default: base = a ^ b;
        endcase
        return base ^ inv;
    endfunction

    task automatic check(string req, logic act, logic expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, expv);
        end
    endtask

    // advance the model over the edge just passed, using the inputs held before it
    task automatic model_step();
        logic tk, filt, e, cond, n_lvl;
        int   n_st, n_cnt;
        tk    = cfg_fast_sel ? tick_fast : tick_slow;           // R5
        filt  = cfg_filt_en ? m_lvl : m_s2;                      // R3
        e     = exp_of(cfg_exp_sel, pat0, pat1, cfg_invert);
        cond  = !cfg_drive && (filt != e);                       // R9
        n_st  = m_st; n_cnt = m_cnt; n_lvl = m_lvl;
        case (m_st)                                              // R4
            0: begin n_lvl = m_s2; n_cnt = 0; n_st = cfg_filt_en ? 1 : 0; end
            1: begin n_cnt = 0;
                     n_st = !cfg_filt_en ? 0 : ((m_s2 != m_lvl) ? 2 : 1); end
            default: begin
                if (!cfg_filt_en) n_st = 0;
                else if (m_s2 == m_lvl) n_st = 1;
                if (cfg_filt_en && m_s2 != m_lvl && tk && m_cnt >= int'(cfg_width)) begin
                    n_st = 1; n_lvl = m_s2; n_cnt = 0;
                end else if (tk) n_cnt = (m_cnt + 1) % 64;
            end
        endcase
        m_mm = cond && !m_diff; m_diff = cond;
        m_st = n_st; m_cnt = n_cnt; m_lvl = n_lvl;
        m_s2 = m_s1; m_s1 = pin_raw;                             // R2
    endtask

    task automatic step_regs();
        @(negedge clk);
        model_step();
        check("R2 raw_rd", raw_rd, m_s2);
        check("R3 R4 R5 R6 R7 R9 mismatch", mismatch, m_mm);
    endtask

    task automatic check_comb();
        logic e;
        #1;
        e = exp_of(cfg_exp_sel, pat0, pat1, cfg_invert);
        check("R8 pin_oe", pin_oe, cfg_drive);
        check("R6 R7 R8 pin_out", pin_out, cfg_drive ? ~e : 1'b0);
    endtask

    task automatic hold(int n);
        for (int i = 0; i < n; i++) begin
            step_regs();
            check_comb();
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        pin_raw = 1'b1;
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 raw_rd", raw_rd, 1'b0);
            check("R1 mismatch", mismatch, 1'b0);
        end
        pin_raw = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        hold(4);

        // R4/R5 directed: fast tick every cycle, width 3, compare to 0
        cfg_filt_en = 1; cfg_fast_sel = 1; tick_fast = 1; cfg_width = 6'd3;
        hold(6);
        pin_raw = 1; hold(4); pin_raw = 0; hold(10);    // short glitch, aborted
        pin_raw = 1; hold(12);                         // long hold, accepted
        pin_raw = 0; hold(12);
        // R5: slow tick selected, fast strobes ignored
        cfg_fast_sel = 0; cfg_width = 6'd1; pin_raw = 1;
        for (int i = 0; i < 30; i++) begin
            step_regs();
            tick_slow = (i % 7 == 6);
            check_comb();
        end
        // R3: bypass
        cfg_filt_en = 0; pin_raw = 0; hold(6); pin_raw = 1; hold(6);
        // R8: driving
        cfg_drive = 1; cfg_exp_sel = 2'b11; pat0 = 1; hold(4); cfg_drive = 0; hold(4);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            step_regs();
            if (i % 24 == 0) begin
                cfg_width    = 6'($urandom_range(0, 3));
                cfg_fast_sel = 1'($urandom);
                cfg_filt_en  = ($urandom_range(0, 3) != 0);
                cfg_exp_sel  = 2'($urandom);
                cfg_invert   = 1'($urandom);
                cfg_drive    = ($urandom_range(0, 4) == 0);
            end
            if ($urandom_range(0, 9) == 0) pin_raw = ~pin_raw;
            tick_fast = ($urandom_range(0, 1) == 0);
            tick_slow = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 7) == 0) pat0 = 1'($urandom);
            if ($urandom_range(0, 7) == 0) pat1 = 1'($urandom);
            check_comb();
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule